// File: doc/BRIEF.md
# Noise-Filtered Edge Interrupt Input

This block conditions one external input pin before it reaches an interrupt flag and a timer event line. The pin is first brought into the clock domain by a two-stage synchroniser. A digital filter then passes a new level only after the synchronised input has held that level for a selectable number of consecutive instruction-cycle samples. The filter constant is 1, 32 or 128 samples. A sample is taken only on clocks where the instruction-cycle enable is high.

The filtered level feeds an edge detector. The detector accepts rising edges, falling edges, both edges or none. It never responds to a steady level. Each accepted edge produces a one-clock event pulse for a timer/counter and sets a sticky interrupt flag. Software clears the flag with a write-1 clear strobe.

The filter is a small state machine with three states:
- FS_INIT: holds for the synchroniser depth after reset, then adopts the synchronised level without reporting a change (transition INIT→STABLE).
- FS_STABLE: the filtered level matches the input. A differing sample either commits at once when the constant is 1 (STABLE→STABLE commit) or starts a qualification count (STABLE→PENDING).
- FS_PENDING: counts differing samples. A matching sample abandons the count (PENDING→STABLE abort). Reaching the constant commits the new level (PENDING→STABLE commit).

Top module: `glitch_reject_irq`

## Requirements
- R1: The filter select `flt_sel_i` encodes the constant: 2'b00 = 1 sample, 2'b01 = 32 samples, 2'b10 and 2'b11 = 128 samples. A new level is passed if and only if the synchronised input holds it for at least that many consecutive samples.
- R2: If the synchronised input returns to the current filtered level before the constant is reached, the qualification count restarts from zero. Two short pulses separated by a short gap are therefore both rejected.
- R3: Samples are counted only on clocks with `cyc_en_i` high. While `cyc_en_i` is low, the filtered level does not change.
- R4: The edge select `edge_sel_i` encodes acceptance: 2'b00 = none, 2'b01 = rising, 2'b10 = falling, 2'b11 = both. A steady level, high or low, produces no events. With 2'b00, no event occurs and the flag is not set.
- R5: Take the filter constant as 1 and hold `cyc_en_i` high. A pin change made between clock edges then appears on `evt_o` during the cycle after the fourth rising edge that follows the change. The pulse is high for exactly one clock. The path counts two synchroniser stages, one filter register and one event register.
- R6: `irq_flag_o` is set by every accepted edge, in the same clock as the event pulse. It stays set until `irq_clr_i` is sampled high. If a clear and an accepted edge coincide, the flag ends set.
- R7: After reset, the filter adopts the pin's settled level without producing an edge. A pin held high through reset gives no event and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw asynchronous input pin |
| cyc_en_i | input | 1 | Instruction-cycle enable; a filter sample is taken when high |
| flt_sel_i | input | 2 | Filter constant select (R1) |
| edge_sel_i | input | 2 | Edge acceptance select (R4) |
| irq_clr_i | input | 1 | Write-1 clear strobe for the interrupt flag |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| evt_o | output | 1 | One-clock event pulse for a timer/counter |

## Verification
The hardest situation to reach is a clear strobe that lands in exactly the clock in which an accepted edge sets the flag. The bench reaches it by using the fixed four-edge latency with constant 1. It changes the pin at a falling clock edge and raises the clear strobe just before the fourth rising edge. The count-restart path also needs care: the stimulus uses pulses just below and exactly at each constant, and pulse pairs whose gap is shorter or longer than the constant. The duty-cycled enable run uses pulse widths that give 30 and 35 samples around the 32-sample constant.

// File: rtl/gri_pkg.sv
package gri_pkg;

    typedef enum logic [1:0] {
        FS_INIT    = 2'b00,
        FS_STABLE  = 2'b01,
        FS_PENDING = 2'b10
    } flt_state_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    localparam logic [1:0] FSEL_FAST = 2'b00;
    localparam logic [1:0] FSEL_MID  = 2'b01;

endpackage

// File: rtl/gri_sync.sv
module gri_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gri_filter.sv
module gri_filter
    import gri_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_LEN    = 1,
    parameter int MID_LEN     = 32,
    parameter int SLOW_LEN    = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic       cyc_en_i,
    input  logic [1:0] sel_i,
    output logic       level_o,
    output logic       chg_o
);
    localparam int CNT_W  = $clog2(SLOW_LEN + 1);
    localparam int FILL_W = $clog2(SYNC_STAGES + 1);

    flt_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [FILL_W-1:0] fill_q;
    logic              level_q;
    logic              chg_q;
    logic              differ;
    logic              last;
    logic              filled;
    logic              single;

    always_comb begin
        unique case (sel_i)
            FSEL_FAST: limit = CNT_W'(FAST_LEN);
            FSEL_MID:  limit = CNT_W'(MID_LEN);
            default:   limit = CNT_W'(SLOW_LEN);
        endcase
    end

    assign differ = (sync_i != level_q);
    assign last   = (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
    assign filled = (fill_q == FILL_W'(SYNC_STAGES));
    assign single = (limit <= CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_INIT: begin
                if (filled) state_d = FS_STABLE;
            end
            FS_STABLE: begin
                if (cyc_en_i && differ && !single) state_d = FS_PENDING;
            end
            FS_PENDING: begin
                if (cyc_en_i && (!differ || last)) state_d = FS_STABLE;
            end
            default: state_d = FS_INIT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= '0;
            cnt_q   <= '0;
            level_q <= 1'b0;
            chg_q   <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            unique case (state_q)
                FS_INIT: begin
                    if (filled) level_q <= sync_i;
                    else        fill_q  <= fill_q + 1'b1;
                    cnt_q <= '0;
                end
                FS_STABLE: begin
                    cnt_q <= '0;
                    if (cyc_en_i && differ) begin
                        if (single) begin
                            level_q <= sync_i;
                            chg_q   <= 1'b1;
                        end else begin
                            cnt_q <= CNT_W'(1);
                        end
                    end
                end
                FS_PENDING: begin
                    if (cyc_en_i) begin
                        if (!differ) begin
                            cnt_q <= '0;
                        end else if (last) begin
                            level_q <= sync_i;
                            chg_q   <= 1'b1;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign level_o = level_q;
    assign chg_o   = chg_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FS_INIT && !cyc_en_i) |=> $stable(level_q)); // R3
    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_INIT) |=> !chg_q); // R7
    AST_CHG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (level_q != $past(level_q))); // R1
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_PENDING && cyc_en_i && !differ) |=> (cnt_q == '0 && !chg_q)); // R2
endmodule

// File: rtl/gri_edge.sv
module gri_edge
    import gri_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       chg_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    output logic       evt_o,
    output logic       flag_o
);
    logic hit;
    logic evt_q;
    logic flag_q;

    always_comb begin
        unique case (edge_mode_t'(mode_i))
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = chg_i & level_i;
            EDGE_FALL: hit = chg_i & ~level_i;
            EDGE_BOTH: hit = chg_i;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            evt_q <= hit;
            if (hit)        flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign evt_o  = evt_q;
    assign flag_o = flag_q;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_NONE) |=> !evt_q); // R4
    AST_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_i |=> !evt_q); // R4
    AST_FLAG_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> flag_q); // R6
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !chg_i) |=> !flag_q); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R6
endmodule

// File: rtl/glitch_reject_irq.sv
module glitch_reject_irq #(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_LEN    = 1,
    parameter int MID_LEN     = 32,
    parameter int SLOW_LEN    = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       cyc_en_i,
    input  logic [1:0] flt_sel_i,
    input  logic [1:0] edge_sel_i,
    input  logic       irq_clr_i,
    output logic       irq_flag_o,
    output logic       evt_o
);
    logic pin_sync;
    logic filt_level;
    logic filt_chg;

    gri_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    gri_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FAST_LEN    (FAST_LEN),
        .MID_LEN     (MID_LEN),
        .SLOW_LEN    (SLOW_LEN)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_sync),
        .cyc_en_i (cyc_en_i),
        .sel_i    (flt_sel_i),
        .level_o  (filt_level),
        .chg_o    (filt_chg)
    );

    gri_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (filt_level),
        .chg_i   (filt_chg),
        .mode_i  (edge_sel_i),
        .clr_i   (irq_clr_i),
        .evt_o   (evt_o),
        .flag_o  (irq_flag_o)
    );

    AST_EVT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(edge_sel_i) != 2'b00)); // R4
endmodule

// File: tb/sim_glitch_reject_irq.sv
module sim_glitch_reject_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       cyc_en = 1'b1;
    logic [1:0] fsel = 2'b00;
    logic [1:0] esel = 2'b00;
    logic       clr = 1'b0;
    logic       flag;
    logic       evt;

    int checks = 0;
    int errors = 0;
    int evt_cnt = 0;
    bit counting = 1'b0;
    bit div_mode = 1'b0;
    bit en_off = 1'b0;
    int phase = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    glitch_reject_irq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin),
        .cyc_en_i   (cyc_en),
        .flt_sel_i  (fsel),
        .edge_sel_i (esel),
        .irq_clr_i  (clr),
        .irq_flag_o (flag),
        .evt_o      (evt)
    );

    always @(negedge clk) begin
        if (counting && evt) evt_cnt++;
        phase = (phase + 1) % 4;
        if (en_off)        cyc_en = 1'b0;
        else if (div_mode) cyc_en = (phase == 0);
        else               cyc_en = 1'b1;
    end

    typedef struct packed {
        logic [1:0]  fs;
        logic [1:0]  es;
        logic [15:0] w;
        logic [15:0] g;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'b00, 2'b01, 16'd2,   16'd0},
        '{2'b00, 2'b11, 16'd1,   16'd0},
        '{2'b01, 2'b01, 16'd31,  16'd0},
        '{2'b01, 2'b01, 16'd32,  16'd0},
        '{2'b01, 2'b11, 16'd64,  16'd0},
        '{2'b01, 2'b10, 16'd20,  16'd5},
        '{2'b10, 2'b11, 16'd127, 16'd0},
        '{2'b10, 2'b11, 16'd128, 16'd0},
        '{2'b11, 2'b01, 16'd130, 16'd0},
        '{2'b01, 2'b11, 16'd40,  16'd10},
        '{2'b01, 2'b11, 16'd40,  16'd40},
        '{2'b00, 2'b00, 16'd50,  16'd0},
        '{2'b10, 2'b10, 16'd100, 16'd60}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int flen(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 32;
        return 128;
    endfunction

    task automatic clear_flag();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R7 reset state
        clocks(3);
        chk("R7 flag in reset", int'(flag), 0);
        chk("R7 evt in reset", int'(evt), 0);
        @(negedge clk) rst_n = 1'b1;
        clocks(20);

        // table walk: R1, R2, R4
        for (int v = 0; v < NVEC; v++) begin
            int n;
            int acc;
            int exp_cnt;
            vec_t t;
            t = VECS[v];
            fsel = t.fs;
            esel = t.es;
            pin = 1'b0;
            clocks(300);
            clear_flag();
            evt_cnt = 0;
            counting = 1'b1;
            pin = 1'b1;
            clocks(int'(t.w));
            pin = 1'b0;
            if (t.g != 0) begin
                clocks(int'(t.g));
                pin = 1'b1;
                clocks(int'(t.w));
                pin = 1'b0;
            end
            clocks(300);
            counting = 1'b0;
            n = flen(t.fs);
            if (int'(t.w) < n)                       acc = 0;
            else if (t.g == 0)                       acc = 1;
            else if (int'(t.g) >= n)                 acc = 2;
            else                                     acc = 1;
            exp_cnt = acc * (int'(t.es[0]) + int'(t.es[1]));
            chk($sformatf("R1/R2/R4 vector %0d events", v), evt_cnt, exp_cnt);
            chk($sformatf("R6 vector %0d flag", v), int'(flag), (exp_cnt > 0) ? 1 : 0);
        end

        // R5 latency and single-clock pulse
        fsel = 2'b00;
        esel = 2'b01;
        pin = 1'b0;
        clocks(20);
        clear_flag();
        @(negedge clk) pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) chk("R5 evt before 4th edge", int'(evt), 0);
        @(posedge clk);
        @(negedge clk) chk("R5 evt after 4th edge", int'(evt), 1);
        @(posedge clk);
        @(negedge clk) chk("R5 evt one clock", int'(evt), 0);

        // R4 steady high gives no retrigger; R6 flag holds
        evt_cnt = 0;
        counting = 1'b1;
        clocks(200);
        counting = 1'b0;
        chk("R4 steady level events", evt_cnt, 0);
        chk("R6 flag sticky", int'(flag), 1);

        // R6 clear
        clear_flag();
        @(negedge clk) chk("R6 flag cleared", int'(flag), 0);

        // R6 clear coinciding with accepted edge
        esel = 2'b11;
        clocks(5);
        @(negedge clk) pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) clr = 1'b1;
        @(posedge clk);
        @(negedge clk) begin
            clr = 1'b0;
            chk("R6 set wins over clear (flag)", int'(flag), 1);
            chk("R6 set wins over clear (evt)", int'(evt), 1);
        end
        clear_flag();

        // R3 duty-cycled enable, constant 32, edge both
        fsel = 2'b01;
        div_mode = 1'b1;
        clocks(20);
        evt_cnt = 0;
        counting = 1'b1;
        pin = 1'b1;
        clocks(120);
        pin = 1'b0;
        clocks(400);
        chk("R3 30 samples rejected", evt_cnt, 0);
        evt_cnt = 0;
        pin = 1'b1;
        clocks(140);
        pin = 1'b0;
        clocks(400);
        chk("R3 35 samples accepted", evt_cnt, 2);
        counting = 1'b0;
        div_mode = 1'b0;

        // R3 enable held low: no change at all
        en_off = 1'b1;
        clocks(5);
        evt_cnt = 0;
        counting = 1'b1;
        pin = 1'b1;
        clocks(300);
        counting = 1'b0;
        chk("R3 no samples no change", evt_cnt, 0);
        pin = 1'b0;
        clocks(10);
        en_off = 1'b0;
        clocks(50);
        clear_flag();

        // R7 pin high through reset: adopted silently
        @(negedge clk) begin
            rst_n = 1'b0;
            pin = 1'b1;
            esel = 2'b11;
            fsel = 2'b00;
        end
        clocks(5);
        @(negedge clk) rst_n = 1'b1;
        evt_cnt = 0;
        counting = 1'b1;
        clocks(60);
        chk("R7 no edge after reset", evt_cnt, 0);
        chk("R7 flag clear after reset", int'(flag), 0);
        pin = 1'b0;
        clocks(20);
        counting = 1'b0;
        chk("R7 later fall detected once", evt_cnt, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule